// File: doc/BRIEF.md
# Serial Port Status Flags and Interrupt Combiner

This block keeps the six status flags of a serial port that can also carry LIN traffic: received byte waiting, transmit holding register empty, transmit line idle, framing error, overrun and break seen. The transmit and receive engines raise a flag with a one-cycle pulse. The CPU lowers a flag by reading received data, by writing transmit data, or by writing an action bit in the control word. Four interrupt lines are formed from the flags and four enable bits. The receive line groups the received-byte flag with both error flags.

A write of the programmable-clear action restarts the serial engines. It drops every flag and sends a one-cycle soft-reset pulse to the datapaths and the baud generator, and it leaves the enable bits as they were. All ports are plain control and status pins. There is no data stream, so there is no valid/ready handshake.

Top module: `sio_status_irq`

## Requirements
- R1: After reset, `status`, `ctl_rdata`, all four interrupt lines and `soft_rst` are 0.
- R2: A 1 on bit k of `flag_set` makes `status` bit k read 1 after the next clock edge, and the flag stays 1 until a clear action reaches it. Status bits are: 0 received byte waiting, 1 transmit empty, 2 line idle, 3 framing error, 4 overrun, 5 break seen.
- R3: `irq_rx` is 1 exactly when enable bit 0 is 1 and at least one of status bits 0, 3 or 4 is 1.
- R4: `irq_tx` is 1 exactly when enable bit 1 and status bit 1 are both 1.
- R5: `irq_idle` is 1 exactly when enable bit 2 and status bit 2 are both 1.
- R6: `irq_brk` is 1 exactly when enable bit 3 and status bit 5 are both 1.
- R7: A `rx_data_rd` pulse clears status bit 0. A `tx_data_wr` pulse clears status bits 1 and 2. No other bit changes.
- R8: A control write (`ctl_we`) with `ctl_wdata` bit 4 set clears status bits 3 and 4. One with bit 5 set clears status bit 5. Every other flag is left alone, and bits 3..0 of the write load enable bits 3..0.
- R9: When a set pulse and a read, write or error-clear action reach the same flag in the same cycle, the flag ends up 1.
- R10: A control write with `ctl_wdata` bit 6 set clears all six flags after that edge, even against a concurrent set pulse. It raises `soft_rst` for exactly the following cycle and leaves the enable bits unchanged.
- R11: `ctl_rdata` bits 3..0 return the enable bits. Bits 6..4 (the action bits) always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flag_set | input | 6 | One-cycle set pulses from the serial engines, bit order as in R2 |
| rx_data_rd | input | 1 | CPU read of the receive data |
| tx_data_wr | input | 1 | CPU write of the transmit data |
| ctl_we | input | 1 | CPU write of the control word |
| ctl_wdata | input | 7 | Enable bits 3..0, error clear 4, break clear 5, programmable clear 6 |
| ctl_rdata | output | 7 | Control word readback |
| status | output | 6 | Flag readback |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_idle | output | 1 | Line-idle interrupt |
| irq_brk | output | 1 | Break interrupt |
| soft_rst | output | 1 | One-cycle restart pulse to the engines and baud generator |

## Verification
The assertions assume that every input is a known 0 or 1 from the first clock edge on. They also assume that a programmable clear is never written in two back-to-back cycles, so `soft_rst` can be traced to a single write one cycle earlier. The bench drives each input on the falling edge from a defined idle value. It issues every programmable clear as a one-cycle write followed by idle cycles, which keeps both assumptions true throughout the sweeps and the directed cases.

// File: rtl/sio_stat_pkg.sv
package sio_stat_pkg;
  localparam int NFLAG    = 6;
  localparam int NEN      = 4;
  localparam int CTL_W    = 7;

  localparam int F_RXFULL = 0;
  localparam int F_TXEMPT = 1;
  localparam int F_IDLE   = 2;
  localparam int F_FRERR  = 3;
  localparam int F_OVRUN  = 4;
  localparam int F_BREAK  = 5;

  localparam int C_ERRCLR = 4;
  localparam int C_BRKCLR = 5;
  localparam int C_PCLR   = 6;
endpackage

// File: rtl/sio_ctl_regs.sv
module sio_ctl_regs
  import sio_stat_pkg::*;
#(
  parameter int EN_W  = NEN,
  parameter int WD_W  = CTL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [WD_W-1:0] wdata,
  output logic [EN_W-1:0] en,
  output logic            err_clr,
  output logic            brk_clr,
  output logic            pclr,
  output logic            soft_rst,
  output logic [WD_W-1:0] rdata
);
  localparam int ACT_W = WD_W - EN_W;

  // action strobes are decoded straight from the write
  always_comb begin
    err_clr = we & wdata[C_ERRCLR];
    brk_clr = we & wdata[C_BRKCLR];
    pclr    = we & wdata[C_PCLR];
  end

  // a restart write keeps the configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0;
    end else if (we && !wdata[C_PCLR]) begin
      en <= wdata[EN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_rst <= 1'b0;
    else        soft_rst <= pclr;
  end

  assign rdata = {{ACT_W{1'b0}}, en};
endmodule

// File: rtl/sio_flag_bank.sv
module sio_flag_bank
  import sio_stat_pkg::*;
#(
  parameter int N = NFLAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic         kill,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (kill)   q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_irq_merge.sv
module sio_irq_merge
  import sio_stat_pkg::*;
#(
  parameter int N    = NFLAG,
  parameter int EN_W = NEN
) (
  input  logic [N-1:0]    flags,
  input  logic [EN_W-1:0] en,
  output logic            irq_rx,
  output logic            irq_tx,
  output logic            irq_idle,
  output logic            irq_brk
);
  logic rx_cause;

  always_comb begin
    rx_cause = flags[F_RXFULL] | flags[F_FRERR] | flags[F_OVRUN];
    irq_rx   = en[0] & rx_cause;
    irq_tx   = en[1] & flags[F_TXEMPT];
    irq_idle = en[2] & flags[F_IDLE];
    irq_brk  = en[3] & flags[F_BREAK];
  end
endmodule

// File: rtl/sio_status_irq.sv
module sio_status_irq
  import sio_stat_pkg::*;
#(
  parameter int N    = NFLAG,
  parameter int EN_W = NEN,
  parameter int WD_W = CTL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    flag_set,
  input  logic            rx_data_rd,
  input  logic            tx_data_wr,
  input  logic            ctl_we,
  input  logic [WD_W-1:0] ctl_wdata,
  output logic [WD_W-1:0] ctl_rdata,
  output logic [N-1:0]    status,
  output logic            irq_rx,
  output logic            irq_tx,
  output logic            irq_idle,
  output logic            irq_brk,
  output logic            soft_rst
);
  logic [EN_W-1:0] en;
  logic            err_clr, brk_clr, pclr;
  logic [N-1:0]    clr_vec;

  sio_ctl_regs #(.EN_W(EN_W), .WD_W(WD_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ctl_we),
    .wdata   (ctl_wdata),
    .en      (en),
    .err_clr (err_clr),
    .brk_clr (brk_clr),
    .pclr    (pclr),
    .soft_rst(soft_rst),
    .rdata   (ctl_rdata)
  );

  always_comb begin
    clr_vec           = '0;
    clr_vec[F_RXFULL] = rx_data_rd;
    clr_vec[F_TXEMPT] = tx_data_wr;
    clr_vec[F_IDLE]   = tx_data_wr;
    clr_vec[F_FRERR]  = err_clr;
    clr_vec[F_OVRUN]  = err_clr;
    clr_vec[F_BREAK]  = brk_clr;
  end

  sio_flag_bank #(.N(N)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (flag_set),
    .clr  (clr_vec),
    .kill (pclr),
    .q    (status)
  );

  sio_irq_merge #(.N(N), .EN_W(EN_W)) u_irq (
    .flags   (status),
    .en      (en),
    .irq_rx  (irq_rx),
    .irq_tx  (irq_tx),
    .irq_idle(irq_idle),
    .irq_brk (irq_brk)
  );
endmodule

// File: rtl/sio_status_irq_chk.sv
module sio_status_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] flag_set,
  input logic       rx_data_rd,
  input logic       ctl_we,
  input logic [6:0] ctl_wdata,
  input logic [6:0] ctl_rdata,
  input logic [5:0] status,
  input logic       irq_rx,
  input logic       irq_tx,
  input logic       soft_rst
);
  logic pclr_wr;
  assign pclr_wr = ctl_we & ctl_wdata[6];

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pclr_wr && (flag_set != 6'd0)) |=> ((status & $past(flag_set)) == $past(flag_set)));

  // R3
  rx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> (ctl_rdata[0] && (status[0] || status[3] || status[4])));

  // R4
  tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[1] && status[1]) |-> irq_tx);

  // R8
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[4] && !ctl_wdata[6] && !flag_set[3] && !flag_set[4])
      |=> (!status[3] && !status[4]));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set[0] && rx_data_rd && !pclr_wr) |=> status[0]);

  // R10
  pclr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pclr_wr |=> (status == 6'd0 && soft_rst));

  // R10
  pclr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pclr_wr |=> (ctl_rdata[3:0] == $past(ctl_rdata[3:0])));

  // R10
  soft_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_rst) |-> $past(pclr_wr));
endmodule

bind sio_status_irq sio_status_irq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flag_set  (flag_set),
  .rx_data_rd(rx_data_rd),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .ctl_rdata (ctl_rdata),
  .status    (status),
  .irq_rx    (irq_rx),
  .irq_tx    (irq_tx),
  .soft_rst  (soft_rst)
);

// File: tb/test_sio_status_irq.sv
`timescale 1ns/1ps
module test_sio_status_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] flag_set = '0;
  logic       rx_data_rd = 1'b0;
  logic       tx_data_wr = 1'b0;
  logic       ctl_we = 1'b0;
  logic [6:0] ctl_wdata = '0;
  logic [6:0] ctl_rdata;
  logic [5:0] status;
  logic       irq_rx, irq_tx, irq_idle, irq_brk, soft_rst;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  sio_status_irq i_sio_status_irq (
    .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .rx_data_rd(rx_data_rd),
    .tx_data_wr(tx_data_wr), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .status(status), .irq_rx(irq_rx), .irq_tx(irq_tx),
    .irq_idle(irq_idle), .irq_brk(irq_brk), .soft_rst(soft_rst)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ctl_write(input logic [6:0] d);
    ctl_we = 1'b1; ctl_wdata = d; step();
    ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic pulse_set(input logic [5:0] f);
    flag_set = f; step(); flag_set = '0;
  endtask

  function automatic logic [3:0] exp_irq(input logic [5:0] f, input logic [3:0] e);
    return {e[3] & f[5], e[2] & f[2], e[1] & f[1], e[0] & (f[0] | f[3] | f[4])};
  endfunction

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    // R1 reset state
    chk("R1 status", {26'd0, status}, 32'd0);
    chk("R1 ctl_rdata", {25'd0, ctl_rdata}, 32'd0);
    chk("R1 irqs", {27'd0, irq_brk, irq_idle, irq_tx, irq_rx, soft_rst}, 32'd0);
    rst_n = 1'b1;
    step();

    // R2..R6, R11: all flag patterns against all enable patterns
    for (int f = 0; f < 64; f++) begin
      ctl_write(7'h40); step();
      pulse_set(6'(f));
      chk("R2 flag set", {26'd0, status}, {26'd0, 6'(f)});
      for (int e = 0; e < 16; e++) begin
        ctl_write(7'(e));
        chk("R11 enable readback", {25'd0, ctl_rdata}, {25'd0, 7'(e)});
        chk("R3 R4 R5 R6 irq", {28'd0, irq_brk, irq_idle, irq_tx, irq_rx},
            {28'd0, exp_irq(6'(f), 4'(e))});
      end
    end

    // R7 read and write clears
    ctl_write(7'h00);
    pulse_set(6'h3F);
    rx_data_rd = 1'b1; step(); rx_data_rd = 1'b0;
    chk("R7 rx read clear", {26'd0, status}, 32'h3E);
    tx_data_wr = 1'b1; step(); tx_data_wr = 1'b0;
    chk("R7 tx write clear", {26'd0, status}, 32'h38);

    // R8 error and break clear
    pulse_set(6'h3F);
    ctl_write(7'h15);
    chk("R8 error clear", {26'd0, status}, 32'h27);
    chk("R8 enables loaded", {25'd0, ctl_rdata}, 32'h05);
    ctl_write(7'h25);
    chk("R8 break clear", {26'd0, status}, 32'h07);
    chk("R11 action bits read 0", {29'd0, ctl_rdata[6:4]}, 32'd0);

    // R9 set beats clear in same cycle
    flag_set = 6'h3F; rx_data_rd = 1'b1; tx_data_wr = 1'b1;
    ctl_we = 1'b1; ctl_wdata = 7'h35;
    step();
    flag_set = '0; rx_data_rd = 1'b0; tx_data_wr = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
    chk("R9 set wins", {26'd0, status}, 32'h3F);

    // R10 programmable clear
    ctl_write(7'h0F);
    chk("R10 pre irqs", {28'd0, irq_brk, irq_idle, irq_tx, irq_rx}, 32'hF);
    chk("R10 soft_rst idle", {31'd0, soft_rst}, 32'd0);
    flag_set = 6'h3F; ctl_we = 1'b1; ctl_wdata = 7'h40;
    step();
    flag_set = '0; ctl_we = 1'b0; ctl_wdata = '0;
    chk("R10 flags cleared", {26'd0, status}, 32'd0);
    chk("R10 soft_rst high", {31'd0, soft_rst}, 32'd1);
    chk("R10 enables kept", {25'd0, ctl_rdata}, 32'h0F);
    chk("R10 irqs low", {28'd0, irq_brk, irq_idle, irq_tx, irq_rx}, 32'd0);
    step();
    chk("R10 soft_rst one cycle", {31'd0, soft_rst}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule